// File: doc/BRIEF.md
# Reference Selection State Controller

This block decides which of two timing references drives a clock recovery loop, and it sets the loop mode around each change of reference. A request to change reference does not take effect at once. The controller first puts the loop into a short holdover, with phase-transient smoothing switched off. It then adopts the requested reference and goes back to Normal, where the smoothing enable again follows its external pin.

If the reference in use is reported as unusable, the controller drops into an automatic holdover. It leaves that holdover as soon as the reference is reported good again. Whenever a holdover is entered from Normal, the block raises a one-cycle snapshot request. It also latches a frequency word from a small history that is sampled at a slow tick, so that the holdover frequency comes from loop state a few ticks before the disturbance.

The phase detector, the loop filter and the measurement that judges whether a reference is valid are outside this block. The validity result arrives as a flag input.

Top module: `refsel_ctrl`

## Requirements
- R1: After synchronous reset the mode is Normal (code 2'b00), reference 0 is selected, the snapshot request is low and the held frequency word is zero.
- R2: The selected reference index changes only when Short Holdover ends. It then takes the synchronised select level, where level 0 means reference 0 and level 1 means reference 1.
- R3: Any transition of the select input moves the mode to Short Holdover (code 2'b01) from Normal or from Auto Holdover. The mode output shows the change on the third rising edge after the input changes, because of the two-flop synchroniser and the edge register.
- R4: While the mode is Short Holdover, the effective smoothing enable is 0 whatever the level of the enable pin.
- R5: With no further select transition, Short Holdover lasts exactly SHORT_CYC cycles and is followed by Normal.
- R6: A select transition seen during Short Holdover restarts the count, so Normal is reached SHORT_CYC cycles after the last transition was detected.
- R7: In Normal and Auto Holdover the effective smoothing enable equals the enable pin, and it follows the pin in the same cycle.
- R8: In Normal with no select transition, a low valid flag gives Auto Holdover (code 2'b10) on the next edge. In Auto Holdover, a high valid flag gives Normal on the next edge.
- R9: The snapshot request is high for exactly the first cycle of a holdover entered from Normal. A move from Auto Holdover into Short Holdover does not raise it.
- R10: The held word loads one cycle after the snapshot request. It takes history entry LAG_IDX, where entry 0 is the word sampled on the most recent history tick, entry 1 the tick before that, and so on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_in | input | 1 | Asynchronous reference select level |
| ref_valid | input | 1 | High when the selected reference is usable |
| smooth_en_pin | input | 1 | External enable for phase-transient smoothing |
| hist_tick | input | 1 | One-cycle strobe that samples freq_word into the history |
| freq_word | input | FW | Current loop frequency word |
| ref_idx | output | 1 | Index of the reference in use |
| mode | output | 2 | 00 Normal, 01 Short Holdover, 10 Auto Holdover |
| smooth_en | output | 1 | Effective phase-transient smoothing enable |
| snap_req | output | 1 | One-cycle request to freeze the holdover frequency |
| hold_word | output | FW | Frequency word latched for holdover |

## Verification
The bench builds the block with SHORT_CYC set to 16, a four-entry history and LAG_IDX of 2. The short window is then small enough to check both of its boundary cycles, and a restart in the middle of the window fits into a few dozen cycles. The history is filled with distinct words, so any capture from the wrong entry shows up as a wrong value. The sequences cover a switch away from each reference, a restart partway through the window, entry into and exit from automatic holdover, and a select change made during automatic holdover.

// File: rtl/refsel_pkg.sv
// Shared types for the reference selection controller.
package refsel_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_SHORT  = 2'b01,
        MODE_AUTO   = 2'b10
    } mode_t;
endpackage

// File: rtl/refsel_sync.sv
// Multi-flop synchroniser for one asynchronous level.
// Assumes the input is a slow level; the output is STAGES cycles late.
module refsel_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Purpose: capture the raw level in the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                // Purpose: pass the level on through later stages.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/refsel_fsm.sv
// Mode sequencer: finds edges on the synchronised select level, runs the
// Normal / Short Holdover / Auto Holdover states, picks the reference and
// gates the smoothing enable. Assumes sel_lvl is already synchronised.
module refsel_fsm
    import refsel_pkg::*;
#(
    parameter int SHORT_CYC = 1024
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sel_lvl,
    input  logic  ref_valid,
    input  logic  en_pin,
    output mode_t mode,
    output logic  ref_idx,
    output logic  smooth_en,
    output logic  snap_req
);
    localparam int CW = (SHORT_CYC > 1) ? $clog2(SHORT_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(SHORT_CYC - 1);

    logic          sel_last;
    logic          sel_edge;
    logic [CW-1:0] cnt, cnt_n;
    mode_t         mode_n;
    logic          ref_n;

    assign sel_edge = sel_lvl ^ sel_last;

    // Purpose: remember the previous synchronised select level.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_last <= 1'b0;
        else        sel_last <= sel_lvl;
    end

    // Purpose: work out the next mode, counter and reference.
    always_comb begin
        mode_n = mode;
        cnt_n  = cnt;
        ref_n  = ref_idx;
        unique case (mode)
            MODE_NORMAL: begin
                if (sel_edge) begin
                    mode_n = MODE_SHORT;
                    cnt_n  = '0;
                end else if (!ref_valid) begin
                    mode_n = MODE_AUTO;
                end
            end
            MODE_SHORT: begin
                if (sel_edge) begin
                    cnt_n = '0;
                end else if (cnt == CNT_LAST) begin
                    mode_n = MODE_NORMAL;
                    ref_n  = sel_lvl;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            MODE_AUTO: begin
                if (sel_edge) begin
                    mode_n = MODE_SHORT;
                    cnt_n  = '0;
                end else if (ref_valid) begin
                    mode_n = MODE_NORMAL;
                end
            end
            default: mode_n = MODE_NORMAL;
        endcase
    end

    // Purpose: register the state and the snapshot pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= MODE_NORMAL;
            cnt      <= '0;
            ref_idx  <= 1'b0;
            snap_req <= 1'b0;
        end else begin
            mode     <= mode_n;
            cnt      <= cnt_n;
            ref_idx  <= ref_n;
            snap_req <= (mode == MODE_NORMAL) && (mode_n != MODE_NORMAL);
        end
    end

    // Purpose: force smoothing off during a reference switch.
    always_comb smooth_en = en_pin && (mode != MODE_SHORT);

    assert_edge_to_short_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_edge |=> mode == MODE_SHORT);

    assert_ref_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_idx != $past(ref_idx)) |-> ($past(mode) == MODE_SHORT && mode == MODE_NORMAL));

    assert_invalid_auto_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_NORMAL && !sel_edge && !ref_valid) |=> mode == MODE_AUTO);

    assert_snap_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req |-> (mode != MODE_NORMAL && $past(mode) == MODE_NORMAL));

    assert_legal_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'b11);
endmodule

// File: rtl/refsel_history.sv
// Frequency history: shifts in a word on each tick and latches entry LAG
// when a snapshot is requested. Assumes ticks are much slower than clk.
module refsel_history #(
    parameter int FW    = 16,
    parameter int DEPTH = 4,
    parameter int LAG   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [FW-1:0] word_in,
    input  logic          snap,
    output logic [FW-1:0] hold_word
);
    logic [FW-1:0] hist [DEPTH];

    // Purpose: shift the history on each tick, newest word in entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
        end else if (tick) begin
            hist[0] <= word_in;
            for (int i = 1; i < DEPTH; i++) hist[i] <= hist[i-1];
        end
    end

    // Purpose: freeze the older entry as the holdover frequency.
    always_ff @(posedge clk) begin
        if (!rst_n)    hold_word <= '0;
        else if (snap) hold_word <= hist[LAG];
    end

    assert_hold_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(snap) |-> hold_word == $past(hist[LAG]));

    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(snap) |-> $stable(hold_word));
endmodule

// File: rtl/refsel_ctrl.sv
// Top of the reference selection controller. Synchronises the select
// input, sequences the modes and keeps the holdover frequency history.
module refsel_ctrl
    import refsel_pkg::*;
#(
    parameter int FW        = 16,
    parameter int SHORT_CYC = 1024,
    parameter int HIST_LEN  = 4,
    parameter int LAG_IDX   = 2,
    parameter int SYNC_FF   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_in,
    input  logic          ref_valid,
    input  logic          smooth_en_pin,
    input  logic          hist_tick,
    input  logic [FW-1:0] freq_word,
    output logic          ref_idx,
    output logic [1:0]    mode,
    output logic          smooth_en,
    output logic          snap_req,
    output logic [FW-1:0] hold_word
);
    logic  sel_s;
    mode_t mode_i;

    refsel_sync #(.STAGES(SYNC_FF)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(sel_in), .q(sel_s)
    );

    refsel_fsm #(.SHORT_CYC(SHORT_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sel_lvl(sel_s), .ref_valid(ref_valid),
        .en_pin(smooth_en_pin), .mode(mode_i), .ref_idx(ref_idx),
        .smooth_en(smooth_en), .snap_req(snap_req)
    );

    refsel_history #(.FW(FW), .DEPTH(HIST_LEN), .LAG(LAG_IDX)) u_hist (
        .clk(clk), .rst_n(rst_n), .tick(hist_tick), .word_in(freq_word),
        .snap(snap_req), .hold_word(hold_word)
    );

    assign mode = mode_i;

    assert_short_no_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |-> !smooth_en);

    assert_en_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b01) |-> (smooth_en == smooth_en_pin));
endmodule

// File: tb/tb_refsel_ctrl.sv
module tb_refsel_ctrl;
    localparam int FW = 16;
    localparam int SC = 16;

    localparam int K_MODE = 0, K_REF = 1, K_EN = 2, K_SNAP = 3, K_HOLD = 4;

    typedef struct {
        int    at;
        int    kind;
        int    val;
        string req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_in = 1'b0;
    logic          ref_valid = 1'b1;
    logic          smooth_en_pin = 1'b1;
    logic          hist_tick = 1'b0;
    logic [FW-1:0] freq_word = '0;
    logic          ref_idx;
    logic [1:0]    mode;
    logic          smooth_en;
    logic          snap_req;
    logic [FW-1:0] hold_word;

    int   cyc = 0;
    int   tests = 0;
    int   fails = 0;
    exp_t q[$];

    refsel_ctrl #(.FW(FW), .SHORT_CYC(SC), .HIST_LEN(4), .LAG_IDX(2), .SYNC_FF(2)) dut (
        .clk(clk), .rst_n(rst_n), .sel_in(sel_in), .ref_valid(ref_valid),
        .smooth_en_pin(smooth_en_pin), .hist_tick(hist_tick), .freq_word(freq_word),
        .ref_idx(ref_idx), .mode(mode), .smooth_en(smooth_en),
        .snap_req(snap_req), .hold_word(hold_word)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Driver side: queue an expected output value for a given cycle.
    task automatic ex(input int at, input int kind, input int val, input string req);
        exp_t e;
        e.at = at; e.kind = kind; e.val = val; e.req = req;
        q.push_back(e);
    endtask

    task automatic go(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Monitor: compare every expectation due in this cycle, mid-period.
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].at == cyc) begin
                int act;
                case (q[i].kind)
                    K_MODE:  act = int'(mode);
                    K_REF:   act = int'(ref_idx);
                    K_EN:    act = int'(smooth_en);
                    K_SNAP:  act = int'(snap_req);
                    default: act = int'(hold_word);
                endcase
                tests++;
                if (act != q[i].val) begin
                    fails++;
                    $display("FAIL %s cycle %0d kind %0d actual %0d expected %0d",
                             q[i].req, cyc, q[i].kind, act, q[i].val);
                end
                q.delete(i);
            end
        end
    end

    initial begin
        #(200000 * 10);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int b;
        go(3);
        rst_n = 1'b1;
        // R1 reset state; R7 enable follows pin in Normal
        ex(cyc, K_MODE, 0, "R1"); ex(cyc, K_REF, 0, "R1");
        ex(cyc, K_SNAP, 0, "R1"); ex(cyc, K_HOLD, 0, "R1");
        ex(cyc, K_EN, 1, "R7");
        go(2);

        // Fill history with 100..105; entry 2 then holds 103
        for (int i = 0; i < 6; i++) begin
            freq_word = FW'(100 + i);
            hist_tick = 1'b1;
            go(1);
            hist_tick = 1'b0;
            go(3);
        end

        // R8 invalid flag gives Auto Holdover; R9 snapshot; R10 capture
        b = cyc;
        ref_valid = 1'b0;
        ex(b + 1, K_MODE, 2, "R8"); ex(b + 1, K_SNAP, 1, "R9");
        ex(b + 1, K_EN, 1, "R7");   ex(b + 2, K_SNAP, 0, "R9");
        ex(b + 2, K_HOLD, 103, "R10");
        go(4);
        b = cyc;
        ref_valid = 1'b1;
        ex(b + 1, K_MODE, 0, "R8"); ex(b + 1, K_SNAP, 0, "R9");
        go(3);

        // R3/R4/R5/R2: switch to reference 1
        b = cyc;
        sel_in = 1'b1;
        ex(b + 2, K_MODE, 0, "R3");  ex(b + 3, K_MODE, 1, "R3");
        ex(b + 3, K_EN, 0, "R4");    ex(b + 3, K_SNAP, 1, "R9");
        ex(b + 3, K_REF, 0, "R2");   ex(b + 3 + SC - 1, K_MODE, 1, "R5");
        ex(b + 3 + SC - 1, K_REF, 0, "R2");
        go(5);
        smooth_en_pin = 1'b0;
        ex(b + 3 + SC, K_MODE, 0, "R5"); ex(b + 3 + SC, K_REF, 1, "R2");
        ex(b + 3 + SC, K_EN, 0, "R7");
        go(3 + SC + 2 - 5);
        smooth_en_pin = 1'b1;
        ex(cyc, K_EN, 1, "R7");
        go(3);

        // R6: second transition mid-window restarts the count
        b = cyc;
        sel_in = 1'b0;
        ex(b + 3, K_MODE, 1, "R3");
        go(8);
        sel_in = 1'b1;
        ex(b + 3 + SC + 1, K_MODE, 1, "R6");
        ex(b + 11 + SC - 1, K_MODE, 1, "R6");
        ex(b + 11 + SC, K_MODE, 0, "R6");
        ex(b + 11 + SC, K_REF, 1, "R2");
        go(11 + SC + 3 - 8);

        // R3 from Auto Holdover; no new snapshot (R9); held word kept (R10)
        b = cyc;
        ref_valid = 1'b0;
        ex(b + 1, K_MODE, 2, "R8");
        go(3);
        b = cyc;
        sel_in = 1'b0;
        ex(b + 3, K_MODE, 1, "R3");  ex(b + 3, K_SNAP, 0, "R9");
        ex(b + 4, K_HOLD, 103, "R10");
        go(5);
        ref_valid = 1'b1;
        ex(b + 3 + SC - 1, K_MODE, 1, "R5");
        ex(b + 3 + SC, K_MODE, 0, "R5");
        ex(b + 3 + SC, K_REF, 0, "R2");
        ex(b + 3 + SC + 1, K_MODE, 0, "R8");
        go(3 + SC + 4 - 5);

        if (q.size() != 0) begin
            fails++;
            tests++;
            $display("FAIL scoreboard actual %0d pending expected 0", q.size());
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule